// File: doc/BRIEF.md
# Long-Term Average Divergence Detector

This block watches a stream of occasional smoothed trend values, such as a moving-average latency figure from a timing monitor. It keeps a long-run cumulative average of those values and a count of how many values are in that average. Each arriving value is compared with the average. A value that sits above the average by more than a programmable margin is treated as divergent and is kept out of the average. A value that does not diverge is folded into the average. When a run of consecutive values diverges, the block raises a failing flag that stays set until reset.

A non-divergent value is normally folded in as avg + (x - avg)/(count + 1). A bit-serial divider does this division and needs several cycles, and the block reports busy while it runs. When the count has reached its maximum, the fold uses a fixed right shift and finishes in one cycle. Values arrive rarely, so the average stays weighted toward the values seen early in life. A load strobe restores a saved average and count, for example after power-up from external storage.

Top module: `trend_drift_monitor`

## Requirements
- R1: After synchronous active-low reset, wear_flag, busy, avg_out and cnt_out are all 0.
- R2: While cnt_out is 0, an accepted sample is always folded in, whatever the margin. When the update completes, avg_out equals the sample and cnt_out is 1.
- R3: A sample is divergent when cnt_out is non-zero, the sample is strictly greater than avg_out, and (sample - avg_out) is strictly greater than margin. A divergent sample leaves avg_out and cnt_out unchanged.
- R4: An accepted non-divergent sample x, with cnt_out n below its maximum, starts an update that holds busy high for DATA_W cycles. The update then sets avg_out to avg ± floor(|x - avg| / (n + 1)), with the sign of x - avg, and sets cnt_out to n + 1.
- R5: A sample presented while busy is high is ignored. It does not change avg_out, cnt_out or the divergence run.
- R6: wear_flag rises on the STREAK_LEN-th consecutive divergent accepted sample. Any accepted non-divergent sample restarts the run.
- R7: wear_flag stays high until reset. Loads and later samples do not clear it, and reset clears it.
- R8: When cnt_out equals its maximum, a non-divergent sample moves avg_out toward the sample by |x - avg| >> SAT_SHIFT in one cycle. busy stays low and cnt_out stays unchanged.
- R9: load_en loads avg_out and cnt_out from load_avg and load_cnt on the next edge, clears the divergence run, and cancels any update in progress. A sample presented in the same cycle is ignored.
- R10: A sample below avg_out is never divergent, whatever the margin, and is folded in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | A trend sample is present this cycle |
| smp_value | input | DATA_W | Trend sample, unsigned |
| margin | input | DATA_W | Allowed excess above the average |
| load_en | input | 1 | Restore average and count |
| load_avg | input | DATA_W | Average to restore |
| load_cnt | input | CNT_W | Count to restore |
| busy | output | 1 | Division update in progress; samples ignored |
| wear_flag | output | 1 | Sticky failing indication |
| avg_out | output | DATA_W | Current long-run average |
| cnt_out | output | CNT_W | Number of samples in the average |

## Verification
The assertions check on every cycle that the flag never falls, and that the flag rises only out of a full run of divergent samples. They also check that the count never falls except on a load, that the run length is frozen while busy, that a load lands its values on the next edge, that a divergent sample leaves the average alone, and that each divider result lies within one divisor of the true quotient. The bench scenarios show the arithmetic itself: the exact averages after truncating division, the shift update at the count limit, the number of busy cycles, that samples during an update have no effect, and that a load wins over a simultaneous sample.

// File: rtl/tdm_pkg.sv
// Package tdm_pkg
// Shared types for the trend drift monitor: the kind of state update
// that the top level performs in a given cycle.
package tdm_pkg;
    typedef enum logic [2:0] {
        UPD_IDLE,     // nothing changes
        UPD_RESTORE,  // external load of average and count
        UPD_SHIFT,    // saturated count: shift-based fold
        UPD_DIVIDE,   // launch the serial division
        UPD_FINISH    // division done: apply quotient
    } upd_kind_t;
endpackage

// File: rtl/trend_avg_divider.sv
// Module trend_avg_divider
// Restoring bit-serial unsigned divider. It produces one quotient bit per
// cycle for DW cycles after start. done pulses in the last busy cycle and
// quotient is valid together with it.
// Assumes: divisor is non-zero, start is only raised while idle, and
// abort cancels at once.
module trend_avg_divider #(
    parameter int DW = 16,
    parameter int VW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          abort,
    input  logic [DW-1:0] dividend,
    input  logic [VW-1:0] divisor,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] quotient
);
    localparam int ITW = $clog2(DW + 1);

    logic [VW-1:0]  rem_q;
    logic [DW-1:0]  quo_q;
    logic [DW-1:0]  dvd_q;
    logic [VW-1:0]  dvs_q;
    logic [ITW-1:0] it_q;
    logic           busy_q;
    logic [VW:0]    trial;
    logic [VW:0]    rem_n;
    logic           ge;
    logic [DW-1:0]  quo_n;

    // One restoring step: shift in the next dividend bit and try to subtract.
    always_comb begin
        trial = {rem_q, quo_q[DW-1]};
        ge    = (trial >= {1'b0, dvs_q});
        rem_n = ge ? (trial - {1'b0, dvs_q}) : trial;
        quo_n = {quo_q[DW-2:0], ge};
    end

    assign busy     = busy_q;
    assign done     = busy_q && (it_q == ITW'(1));
    assign quotient = quo_n;

    // Iteration state: load on start, step while busy, clear on abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quo_q  <= '0;
            dvd_q  <= '0;
            dvs_q  <= '0;
            it_q   <= '0;
            busy_q <= 1'b0;
        end else if (abort) begin
            busy_q <= 1'b0;
            it_q   <= '0;
        end else if (start) begin
            rem_q  <= '0;
            quo_q  <= dividend;
            dvd_q  <= dividend;
            dvs_q  <= divisor;
            it_q   <= ITW'(DW);
            busy_q <= 1'b1;
        end else if (busy_q) begin
            rem_q <= rem_n[VW-1:0];
            quo_q <= quo_n;
            it_q  <= it_q - ITW'(1);
            if (it_q == ITW'(1)) busy_q <= 1'b0;
        end
    end

    logic [DW+VW-1:0] chk_prod;
    assign chk_prod = quotient * dvs_q;

    // R4: the partial remainder always fits below the divisor.
    a_r4_rem_fits: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (rem_n[VW] == 1'b0));

    // R4: the final quotient is the floor of dividend / divisor.
    a_r4_quotient_floor: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((chk_prod <= (DW+VW)'(dvd_q)) &&
                  ((DW+VW)'(dvd_q) - chk_prod < (DW+VW)'(dvs_q))));
endmodule

// File: rtl/trend_streak_tracker.sv
// Module trend_streak_tracker
// Counts consecutive divergent samples and raises a sticky flag on the
// STREAK_LEN-th one. A non-divergent sample or a clear restarts the run.
// Assumes: hit and miss are never high together.
module trend_streak_tracker #(
    parameter int STREAK_LEN = 4,
    parameter int STW        = $clog2(STREAK_LEN + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hit,
    input  logic           miss,
    input  logic           clear,
    output logic [STW-1:0] streak,
    output logic           flag
);
    localparam logic [STW-1:0] LAST = STW'(STREAK_LEN - 1);

    logic [STW-1:0] streak_q;
    logic           flag_q;

    // Run length and sticky flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            streak_q <= '0;
            flag_q   <= 1'b0;
        end else if (clear) begin
            streak_q <= '0;
        end else if (hit) begin
            if (streak_q == LAST) flag_q <= 1'b1;
            else                  streak_q <= streak_q + STW'(1);
        end else if (miss) begin
            streak_q <= '0;
        end
    end

    assign streak = streak_q;
    assign flag   = flag_q;

    // R7: once raised, the flag stays high until reset.
    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q |=> flag_q);

    // R6: the flag rises only on a hit that completes a full run.
    a_r6_flag_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> ($past(streak_q) == LAST && $past(hit)));
endmodule

// File: rtl/trend_drift_monitor.sv
// Module trend_drift_monitor
// Keeps a cumulative average of rare trend samples and flags persistent
// divergence above it. Non-divergent samples are folded in through a
// serial divider, or through a shift once the count saturates.
// Assumes: samples are unsigned; samples arriving while busy are dropped.
module trend_drift_monitor
    import tdm_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int CNT_W      = 8,
    parameter int STREAK_LEN = 4,
    parameter int SAT_SHIFT  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_value,
    input  logic [DATA_W-1:0] margin,
    input  logic              load_en,
    input  logic [DATA_W-1:0] load_avg,
    input  logic [CNT_W-1:0]  load_cnt,
    output logic              busy,
    output logic              wear_flag,
    output logic [DATA_W-1:0] avg_out,
    output logic [CNT_W-1:0]  cnt_out
);
    localparam int               DVW  = CNT_W + 1;
    localparam int               STW  = $clog2(STREAK_LEN + 1);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    logic [DATA_W-1:0] avg_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              down_q;
    logic              accept, above, exceed, saturated;
    logic [DATA_W-1:0] mag;
    logic [DATA_W-1:0] step_sh;
    logic              div_busy, div_done;
    logic [DATA_W-1:0] div_quo;
    logic [STW-1:0]    streak;
    upd_kind_t         kind;

    // Sample classification against the current average.
    always_comb begin
        accept    = smp_valid && !div_busy && !load_en;
        above     = (smp_value > avg_q);
        mag       = above ? (smp_value - avg_q) : (avg_q - smp_value);
        exceed    = (cnt_q != '0) && above && (mag > margin);
        saturated = (cnt_q == CMAX);
        step_sh   = mag >> SAT_SHIFT;
    end

    // Choose which update, if any, this cycle performs.
    always_comb begin
        if (load_en)                             kind = UPD_RESTORE;
        else if (div_done)                       kind = UPD_FINISH;
        else if (accept && !exceed && saturated) kind = UPD_SHIFT;
        else if (accept && !exceed)              kind = UPD_DIVIDE;
        else                                     kind = UPD_IDLE;
    end

    trend_avg_divider #(
        .DW (DATA_W),
        .VW (DVW)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (kind == UPD_DIVIDE),
        .abort    (load_en),
        .dividend (mag),
        .divisor  ({1'b0, cnt_q} + DVW'(1)),
        .busy     (div_busy),
        .done     (div_done),
        .quotient (div_quo)
    );

    trend_streak_tracker #(
        .STREAK_LEN (STREAK_LEN),
        .STW        (STW)
    ) u_streak (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit    (accept && exceed),
        .miss   (accept && !exceed),
        .clear  (load_en),
        .streak (streak),
        .flag   (wear_flag)
    );

    // Average, count and fold direction registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            avg_q  <= '0;
            cnt_q  <= '0;
            down_q <= 1'b0;
        end else begin
            case (kind)
                UPD_RESTORE: begin
                    avg_q <= load_avg;
                    cnt_q <= load_cnt;
                end
                UPD_SHIFT:  avg_q  <= above ? (avg_q + step_sh) : (avg_q - step_sh);
                UPD_DIVIDE: down_q <= !above;
                UPD_FINISH: begin
                    avg_q <= down_q ? (avg_q - div_quo) : (avg_q + div_quo);
                    cnt_q <= cnt_q + CNT_W'(1);
                end
                default: ;
            endcase
        end
    end

    assign busy    = div_busy;
    assign avg_out = avg_q;
    assign cnt_out = cnt_q;

    // R9: a load lands its values on the next edge.
    a_r9_load_restores: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (avg_q == $past(load_avg) && cnt_q == $past(load_cnt)));

    // R4: without a load the count never decreases.
    a_r4_count_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> (cnt_q >= $past(cnt_q)));

    // R5: while busy the divergence run is frozen.
    a_r5_busy_freezes_run: assert property (@(posedge clk) disable iff (!rst_n)
        (div_busy && !load_en) |=> $stable(streak));

    // R3: a divergent sample leaves average and count untouched.
    a_r3_exceed_keeps_avg: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && exceed) |=> ($stable(avg_q) && $stable(cnt_q)));

    // R8: a saturated fold keeps the count and starts no division.
    a_r8_sat_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == UPD_SHIFT) |=> (cnt_q == CMAX && !div_busy));
endmodule

// File: tb/trend_drift_monitor_bench.sv
module trend_drift_monitor_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int CW = 8;
    localparam int WATCHDOG = 20000;

    typedef struct packed {
        logic          ld;
        logic [DW-1:0] x;
        logic [DW-1:0] mg;
        logic [DW-1:0] la;
        logic [CW-1:0] lc;
        logic [DW-1:0] ea;
        logic [CW-1:0] ec;
        logic          ef;
        logic [7:0]    rq;
    } vec_t;

    // Sequence of operations with the state expected after each one.
    localparam int NV = 19;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 16'd100,  16'd10,  16'd0,    8'd0,   16'd100,  8'd1,   1'b0, 8'd2},  // R2 empty fold
        '{1'b0, 16'd120,  16'd10,  16'd0,    8'd0,   16'd100,  8'd1,   1'b0, 8'd3},  // R3 divergent kept out
        '{1'b0, 16'd110,  16'd10,  16'd0,    8'd0,   16'd105,  8'd2,   1'b0, 8'd3},  // R3 equal to margin folds
        '{1'b0, 16'd90,   16'd10,  16'd0,    8'd0,   16'd100,  8'd3,   1'b0, 8'd10}, // R10 below average
        '{1'b0, 16'd200,  16'd10,  16'd0,    8'd0,   16'd100,  8'd3,   1'b0, 8'd6},  // R6 run 1
        '{1'b0, 16'd200,  16'd10,  16'd0,    8'd0,   16'd100,  8'd3,   1'b0, 8'd6},  // R6 run 2
        '{1'b0, 16'd200,  16'd10,  16'd0,    8'd0,   16'd100,  8'd3,   1'b0, 8'd6},  // R6 run 3
        '{1'b0, 16'd104,  16'd10,  16'd0,    8'd0,   16'd101,  8'd4,   1'b0, 8'd6},  // R6 run restarts
        '{1'b0, 16'd133,  16'd40,  16'd0,    8'd0,   16'd107,  8'd5,   1'b0, 8'd4},  // R4 truncation 32/5
        '{1'b1, 16'd0,    16'd0,   16'd1000, 8'd255, 16'd1000, 8'd255, 1'b0, 8'd9},  // R9 restore
        '{1'b0, 16'd1256, 16'd300, 16'd0,    8'd0,   16'd1001, 8'd255, 1'b0, 8'd8},  // R8 shift up
        '{1'b0, 16'd745,  16'd300, 16'd0,    8'd0,   16'd1000, 8'd255, 1'b0, 8'd8},  // R8 shift down
        '{1'b0, 16'd1255, 16'd300, 16'd0,    8'd0,   16'd1000, 8'd255, 1'b0, 8'd8},  // R8 shift truncates
        '{1'b0, 16'd2000, 16'd10,  16'd0,    8'd0,   16'd1000, 8'd255, 1'b0, 8'd6},
        '{1'b0, 16'd2000, 16'd10,  16'd0,    8'd0,   16'd1000, 8'd255, 1'b0, 8'd6},
        '{1'b0, 16'd2000, 16'd10,  16'd0,    8'd0,   16'd1000, 8'd255, 1'b0, 8'd6},
        '{1'b0, 16'd2000, 16'd10,  16'd0,    8'd0,   16'd1000, 8'd255, 1'b1, 8'd6},  // R6 fourth raises
        '{1'b1, 16'd0,    16'd0,   16'd50,   8'd3,   16'd50,   8'd3,   1'b1, 8'd7},  // R7 load keeps flag
        '{1'b0, 16'd56,   16'd10,  16'd0,    8'd0,   16'd51,   8'd4,   1'b1, 8'd7}   // R7 sample keeps flag
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_valid = 1'b0;
    logic [DW-1:0] smp_value = '0;
    logic [DW-1:0] margin = '0;
    logic          load_en = 1'b0;
    logic [DW-1:0] load_avg = '0;
    logic [CW-1:0] load_cnt = '0;
    logic          busy, wear_flag;
    logic [DW-1:0] avg_out;
    logic [CW-1:0] cnt_out;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trend_drift_monitor u_trend_drift_monitor (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_value(smp_value),
        .margin(margin), .load_en(load_en), .load_avg(load_avg), .load_cnt(load_cnt),
        .busy(busy), .wear_flag(wear_flag), .avg_out(avg_out), .cnt_out(cnt_out)
    );

    // Watchdog: an expired run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles >= WATCHDOG) begin
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
            $finish;
        end
    end

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_state(input string req, input longint ea, input longint ec, input longint ef);
        check(req, "avg_out", longint'(avg_out), ea);
        check(req, "cnt_out", longint'(cnt_out), ec);
        check(req, "wear_flag", longint'(wear_flag), ef);
    endtask

    task automatic wait_idle();
        for (int g = 0; g < 100 && busy; g++) @(negedge clk);
    endtask

    task automatic do_sample(input logic [DW-1:0] x, input logic [DW-1:0] mg);
        @(negedge clk);
        smp_valid = 1'b1; smp_value = x; margin = mg;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic do_load(input logic [DW-1:0] a, input logic [CW-1:0] c);
        @(negedge clk);
        load_en = 1'b1; load_avg = a; load_cnt = c;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1", "busy", longint'(busy), 0);
        check_state("R1", 0, 0, 0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            if (TBL[i].ld) do_load(TBL[i].la, TBL[i].lc);
            else           do_sample(TBL[i].x, TBL[i].mg);
            wait_idle();
            check_state($sformatf("R%0d step%0d", TBL[i].rq, i),
                        longint'(TBL[i].ea), longint'(TBL[i].ec), longint'(TBL[i].ef));
        end

        // R7: reset clears the sticky flag
        do_reset();
        check_state("R7", 0, 0, 0);

        // R5 and R4: busy length; samples during busy have no effect
        do_load(16'd100, 8'd1);
        do_sample(16'd110, 16'd50);
        n = 0;
        for (int g = 0; g < 100 && busy; g++) begin
            n++;
            if (g < 4) begin
                smp_valid = 1'b1; smp_value = 16'd5000; margin = 16'd0;
            end else begin
                smp_valid = 1'b0;
            end
            @(negedge clk);
        end
        smp_valid = 1'b0;
        check("R4", "busy cycles", longint'(n), longint'(DW));
        check_state("R5", 105, 2, 0);

        // R9: load during busy cancels the update
        do_sample(16'd125, 16'd50);
        check("R9", "busy before load", longint'(busy), 1);
        load_en = 1'b1; load_avg = 16'd7; load_cnt = 8'd9;
        @(negedge clk);
        load_en = 1'b0;
        repeat (DW + 2) @(negedge clk);
        check("R9", "busy after cancel", longint'(busy), 0);
        check_state("R9", 7, 9, 0);

        // R9: load wins over a simultaneous sample
        @(negedge clk);
        load_en = 1'b1; load_avg = 16'd20; load_cnt = 8'd0;
        smp_valid = 1'b1; smp_value = 16'd900; margin = 16'd0;
        @(negedge clk);
        load_en = 1'b0; smp_valid = 1'b0;
        check("R9", "busy after priority", longint'(busy), 0);
        check_state("R9", 20, 0, 0);

        // R2: empty average folds even a value far above it
        do_sample(16'd900, 16'd0);
        wait_idle();
        check_state("R2", 900, 1, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule